// File: doc/BRIEF.md
# Gated-Window Clock Frequency Counter

This block estimates the frequency of an unknown clock. It counts the rising edges of that clock during a window whose length is a programmable number of ticks of a known reference. The reference tick is a crystal clock divided by a parameter, four by default, and the divider runs only while a branch-enable bit is set. The window timer runs in the crystal domain, the edge counter runs in the measured domain, and a register port runs in the register clock domain. Single-bit controls cross between domains through flop synchronizers. The frozen count returns to the register domain as a Gray code, so a read never returns a partly updated value.

Software first sets the branch bit. It then pulses the clear bit while enable is low, writes the terminal tick count, and sets enable. It polls the done flag and reads the count. The count is not reset while the measured clock is stopped. A short window followed by a long window that give the same count therefore shows that the clock is not running. The rate estimate is (count*10 + 15) * f_ref / (ticks*10 + 35).

Top module: `clkmeas_core`

## Requirements
- R1: Word address 0 is the control register: terminal ticks in bits 19:0, enable in bit 20, clear in bit 21. It reads back what was written, with bits 31:22 as zero. Address 1 is status: count in bits 24:0, done in bit 25. Writes to status are ignored. Address 2 holds the branch bit in bit 0. All other bits and addresses read zero, and every register reads zero after reset.
- R2: The reference tick comes only while the branch bit is 1. With the branch bit at 0, an enabled measurement never sets done and never counts. Setting the branch bit lets the measurement complete.
- R3: With enable at 0, clear returns the window timer to idle within SYNC_STAGES+1 crystal cycles. The status count reads zero once SYNC_STAGES+1 measured-clock cycles and SYNC_STAGES+1 register cycles have passed.
- R4: After enable is set, the window opens on a reference tick and stays open for exactly the terminal number of ticks. Done sets only after the measured domain has stopped counting. Done stays set while enable is 1 and reads 0 as soon as enable is written to 0.
- R5: The count agrees with the relation rate = (count*10+15)*f_ref/(ticks*10+35) within one count.
- R6: After the window closes, the count does not change until the next clear. It reads the same value with enable at 0 and stays stable over time. The value crossing domains changes at most one bit per measured-clock cycle.
- R7: While the measured clock is stopped, neither clear nor a window changes the count. A 16-tick window and a 256-tick window then return the same previous count.
- R8: With SATURATE set, the count stops at all ones (255 for an 8-bit counter) instead of wrapping.
- R9: A terminal count of 0 sets done at the first reference tick without opening the window. The count stays at its cleared value of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| xo_clk | input | 1 | Crystal clock; divided to form the reference tick |
| meas_clk | input | 1 | Clock under measurement |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The in-module assertions check on every cycle that done stays set while enabled, that the window gate and done are never high together, and that clear empties the timer. They also check that the window counter stays below the terminal count, that the count is frozen whenever the gate is low, that the Gray value moves by at most one bit, that a saturated count holds, and that control fields change only on writes. Some behaviour can only be shown by the bench's scenarios. This covers the accuracy of the count against the rate relation, and the effect of the branch bit. It also covers the held count with a stopped measured clock, the clear latency seen at the status register, and the terminal-count-of-zero case.

// File: rtl/clkmeas_pkg.sv
package clkmeas_pkg;
   localparam int unsigned CM_DATA_W      = 32;
   localparam int unsigned CM_TERM_MAX_W  = 20;
   localparam int unsigned CM_CNT_MAX_W   = 25;
   // field positions software decodes
   localparam int unsigned CM_EN_BIT      = 20;
   localparam int unsigned CM_CLR_BIT     = 21;
   localparam int unsigned CM_DONE_BIT    = 25;
   localparam int unsigned CM_BRN_BIT     = 0;
   // word addresses
   localparam int unsigned CM_ADDR_CTRL   = 0;
   localparam int unsigned CM_ADDR_STAT   = 1;
   localparam int unsigned CM_ADDR_BRN    = 2;

   typedef enum logic [2:0] {
      W_IDLE  = 3'd0,
      W_ARM   = 3'd1,
      W_RUN   = 3'd2,
      W_DRAIN = 3'd3,
      W_DONE  = 3'd4
   } cm_win_state_e;
endpackage

// File: rtl/cm_sync.sv
module cm_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cm_window.sv
module cm_window
   import clkmeas_pkg::*;
#(
   parameter int unsigned TERM_W  = 20,
   parameter int unsigned REF_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic              brn,
   input  logic              ack,
   input  logic [TERM_W-1:0] term,
   output logic              gate,
   output logic              done
);
   localparam int unsigned DIV_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

   logic [DIV_W-1:0]  div_q;
   logic              tick;
   cm_win_state_e     state_q;
   logic [TERM_W-1:0] win_q;
   logic [TERM_W-1:0] win_nx;

   assign tick   = brn && (div_q == DIV_W'(REF_DIV - 1));
   assign win_nx = win_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     div_q <= '0;
      else if (!brn)  div_q <= '0;
      else if (tick)  div_q <= '0;
      else            div_q <= div_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= W_IDLE;
         win_q   <= '0;
         gate    <= 1'b0;
         done    <= 1'b0;
      end else if (!en || clr) begin
         state_q <= W_IDLE;
         win_q   <= '0;
         gate    <= 1'b0;
         done    <= 1'b0;
      end else begin
         case (state_q)
            W_IDLE: state_q <= W_ARM;
            W_ARM: if (tick) begin
               win_q <= '0;
               if (term == '0) begin
                  state_q <= W_DRAIN;
               end else begin
                  gate    <= 1'b1;
                  state_q <= W_RUN;
               end
            end
            W_RUN: if (tick) begin
               win_q <= win_nx;
               if (win_nx == term) begin
                  gate    <= 1'b0;
                  state_q <= W_DRAIN;
               end
            end
            W_DRAIN: if (!ack) begin
               done    <= 1'b1;
               state_q <= W_DONE;
            end
            W_DONE: state_q <= W_DONE;
            default: state_q <= W_IDLE;
         endcase
      end
   end

   a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done && en && !clr) |=> done);
   a_r4_gate_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate && done));
   a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> (win_q < term));
   a_r3_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!gate && !done && (win_q == '0)));
endmodule

// File: rtl/cm_edge_cnt.sv
module cm_edge_cnt #(
   parameter int unsigned CNT_W       = 25,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SATURATE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate,
   input  logic             clr,
   output logic [CNT_W-1:0] gray,
   output logic             ack
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [1:0]       ctl_s;
   logic             gate_s;
   logic             clr_s;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_d;

   cm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d({gate, clr}), .q(ctl_s)
   );
   assign gate_s = ctl_s[1];
   assign clr_s  = ctl_s[0];
   assign ack    = gate_s;

   if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
   end else begin : g_wrap
      assign cnt_inc = cnt_q + 1'b1;
   end

   always_comb begin
      if (clr_s)       cnt_d = '0;
      else if (gate_s) cnt_d = cnt_inc;
      else             cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         gray  <= '0;
      end else begin
         cnt_q <= cnt_d;
         gray  <= cnt_d ^ (cnt_d >> 1);
      end
   end

   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_s && !gate_s) |=> $stable(cnt_q));
   a_r6_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s |=> ($countones(gray ^ $past(gray)) <= 1));

   if (SATURATE) begin : g_sat_chk
      a_r8_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_s && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
      a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         !clr_s |=> (cnt_q >= $past(cnt_q)));
   end
endmodule

// File: rtl/cm_gray_rx.sv
module cm_gray_rx #(
   parameter int unsigned CNT_W       = 25,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] gray_in,
   output logic [CNT_W-1:0] bin_out
);
   logic [CNT_W-1:0] gray_s;

   cm_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_gsync (
      .clk(clk), .rst_n(rst_n), .d(gray_in), .q(gray_s)
   );

   always_comb begin
      bin_out[CNT_W-1] = gray_s[CNT_W-1];
      for (int i = CNT_W - 2; i >= 0; i--) begin
         bin_out[i] = bin_out[i+1] ^ gray_s[i];
      end
   end
endmodule

// File: rtl/cm_regs.sv
module cm_regs
   import clkmeas_pkg::*;
#(
   parameter int unsigned TERM_W = 20,
   parameter int unsigned CNT_W  = 25,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [CM_DATA_W-1:0] reg_wdata,
   output logic [CM_DATA_W-1:0] reg_rdata,
   input  logic                 done_s,
   input  logic [CNT_W-1:0]     cnt,
   output logic [TERM_W-1:0]    term,
   output logic                 en,
   output logic                 clr,
   output logic                 brn
);
   logic sel_ctrl, sel_stat, sel_brn;

   assign sel_ctrl = (reg_addr == ADDR_W'(CM_ADDR_CTRL));
   assign sel_stat = (reg_addr == ADDR_W'(CM_ADDR_STAT));
   assign sel_brn  = (reg_addr == ADDR_W'(CM_ADDR_BRN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         term <= '0;
         en   <= 1'b0;
         clr  <= 1'b0;
         brn  <= 1'b0;
      end else if (reg_we) begin
         if (sel_ctrl) begin
            term <= reg_wdata[TERM_W-1:0];
            en   <= reg_wdata[CM_EN_BIT];
            clr  <= reg_wdata[CM_CLR_BIT];
         end
         if (sel_brn) brn <= reg_wdata[CM_BRN_BIT];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_ctrl) begin
         reg_rdata[TERM_W-1:0]  = term;
         reg_rdata[CM_EN_BIT]   = en;
         reg_rdata[CM_CLR_BIT]  = clr;
      end else if (sel_stat) begin
         reg_rdata[CNT_W-1:0]   = cnt;
         reg_rdata[CM_DONE_BIT] = done_s & en;
      end else if (sel_brn) begin
         reg_rdata[CM_BRN_BIT]  = brn;
      end
   end

   a_r1_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> $stable({term, en, clr, brn}));
endmodule

// File: rtl/clkmeas_core.sv
module clkmeas_core
   import clkmeas_pkg::*;
#(
   parameter int unsigned TERM_W      = 20,
   parameter int unsigned CNT_W       = 25,
   parameter int unsigned REF_DIV     = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SATURATE    = 1'b1,
   parameter int unsigned ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xo_clk,
   input  logic              meas_clk,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);
   if (TERM_W < 1 || TERM_W > CM_TERM_MAX_W) begin : g_bad_term
      $error("TERM_W must lie in 1..20");
   end
   if (CNT_W < 2 || CNT_W > CM_CNT_MAX_W) begin : g_bad_cnt
      $error("CNT_W must lie in 2..25");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (REF_DIV < 2) begin : g_bad_div
      $error("REF_DIV must be at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic [TERM_W-1:0] ctl_term;
   logic              ctl_en, ctl_clr, ctl_brn;
   logic [2:0]        ref_ctl;
   logic              ref_ack, ref_gate, ref_done;
   logic [CNT_W-1:0]  meas_gray;
   logic              meas_ack;
   logic              bus_done;
   logic [CNT_W-1:0]  bus_cnt;

   cm_regs #(.TERM_W(TERM_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .done_s(bus_done), .cnt(bus_cnt),
      .term(ctl_term), .en(ctl_en), .clr(ctl_clr), .brn(ctl_brn)
   );

   // register domain -> crystal domain
   cm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_ref_ctl_sync (
      .clk(xo_clk), .rst_n(rst_n), .d({ctl_en, ctl_clr, ctl_brn}), .q(ref_ctl)
   );
   // measured domain -> crystal domain
   cm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ref_ack_sync (
      .clk(xo_clk), .rst_n(rst_n), .d(meas_ack), .q(ref_ack)
   );

   // term is quasi-static: written before enable, held while enabled
   cm_window #(.TERM_W(TERM_W), .REF_DIV(REF_DIV)) u_window (
      .clk(xo_clk), .rst_n(rst_n),
      .en(ref_ctl[2]), .clr(ref_ctl[1]), .brn(ref_ctl[0]), .ack(ref_ack),
      .term(ctl_term), .gate(ref_gate), .done(ref_done)
   );

   cm_edge_cnt #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .SATURATE(SATURATE)) u_edges (
      .clk(meas_clk), .rst_n(rst_n), .gate(ref_gate), .clr(ctl_clr),
      .gray(meas_gray), .ack(meas_ack)
   );

   // back to register domain
   cm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_bus_done_sync (
      .clk(clk), .rst_n(rst_n), .d(ref_done), .q(bus_done)
   );
   cm_gray_rx #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt_rx (
      .clk(clk), .rst_n(rst_n), .gray_in(meas_gray), .bin_out(bus_cnt)
   );
endmodule

// File: tb/sim_clkmeas_core.sv
`timescale 1ns/1ps
module sim_clkmeas_core;
   logic clk = 1'b0, xo = 1'b0, m0 = 1'b0, m1 = 1'b0, rst_n = 1'b0;
   int   m0_half = 100;
   bit   m0_run  = 1'b1;
   logic        we = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata0, rdata1;
   int checks = 0, errors = 0, cyc = 0;
   bit finished = 1'b0;

   localparam logic [31:0] EN_B  = 32'h0010_0000;
   localparam logic [31:0] CLR_B = 32'h0020_0000;

   always #2 clk = ~clk;   // 250 MHz register clock
   always #10 xo = ~xo;    // crystal; tick every 80 ns
   always #3 m1 = ~m1;     // fast clock for the narrow instance
   always begin
      #(m0_half);
      if (m0_run) m0 = ~m0;
   end

   clkmeas_core u0 (
      .clk(clk), .rst_n(rst_n), .xo_clk(xo), .meas_clk(m0),
      .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata0)
   );
   clkmeas_core #(.CNT_W(8)) u1 (
      .clk(clk), .rst_n(rst_n), .xo_clk(xo), .meas_clk(m1),
      .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata1)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 190000 && !finished) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_rate(input string tag, input logic [31:0] cnt, input int ticks, input real r);
      real exp10, diff;
      exp10 = r * real'(ticks * 10 + 35) - 15.0;
      diff  = real'(cnt) * 10.0 - exp10;
      checks++;
      if (diff > 10.0 || diff < -10.0) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0.2f", tag, cnt, exp10 / 10.0);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input bit which, input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1;
      d = which ? rdata1 : rdata0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_done(input int limit);
      logic [31:0] s;
      for (int i = 0; i < limit; i++) begin
         rd(1'b0, 4'd1, s);
         if (s[25]) break;
      end
   endtask

   task automatic start_window(input logic [19:0] t);
      wr(4'd0, CLR_B | {12'd0, t});
      idle(300);
      wr(4'd0, {12'd0, t});
      idle(20);
      wr(4'd0, EN_B | {12'd0, t});
   endtask

   task automatic measure(input logic [19:0] t, output logic [31:0] s);
      start_window(t);
      wait_done(40000);
      rd(1'b0, 4'd1, s);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(1'b0, 4'd0, v); chk("R1 reset ctrl", v, 32'h0);
      rd(1'b0, 4'd1, v); chk("R1 reset status", v, 32'h0);
      rd(1'b0, 4'd2, v); chk("R1 reset branch", v, 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      wr(4'd0, 32'hFFC5_4321);
      rd(1'b0, 4'd0, v); chk("R1 ctrl readback", v, 32'h0005_4321);
      wr(4'd1, 32'hFFFF_FFFF);
      rd(1'b0, 4'd1, v); chk("R1 status write ignored", v, 32'h0);
      wr(4'd2, 32'hFFFF_FFFE);
      rd(1'b0, 4'd2, v); chk("R1 branch upper bits", v, 32'h0);
      rd(1'b0, 4'd3, v); chk("R1 unmapped address", v, 32'h0);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_branch();
      logic [31:0] v;
      wr(4'd2, 32'h0);
      start_window(20'd10);
      idle(1500);
      rd(1'b0, 4'd1, v); chk("R2 no tick without branch", v, 32'h0);
      wr(4'd2, 32'h1);
      wait_done(20000);
      rd(1'b0, 4'd1, v);
      chk("R2 done after branch on", {31'd0, v[25]}, 32'h1);
      chk_rate("R2 count after branch on", {7'd0, v[24:0]}, 10, 0.4);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_rate();
      logic [31:0] v;
      m0_half = 100;
      measure(20'd200, v);
      chk("R4 done set after window", {31'd0, v[25]}, 32'h1);
      chk_rate("R5 ratio 0.4", {7'd0, v[24:0]}, 200, 0.4);
      idle(1000);
      rd(1'b0, 4'd1, v); chk("R4 done held while enabled", {31'd0, v[25]}, 32'h1);
      wr(4'd0, 32'h0);
      m0_half = 80;
      idle(50);
      measure(20'd120, v);
      chk_rate("R5 ratio 0.5", {7'd0, v[24:0]}, 120, 0.5);
      wr(4'd0, 32'h0);
      m0_half = 100;
      idle(50);
   endtask

   task automatic t_hold();
      logic [31:0] v, c;
      measure(20'd50, v);
      c = {7'd0, v[24:0]};
      wr(4'd0, 32'd50);
      rd(1'b0, 4'd1, v);
      chk("R4 done cleared by enable low", {31'd0, v[25]}, 32'h0);
      chk("R6 count kept after enable low", {7'd0, v[24:0]}, c);
      idle(800);
      rd(1'b0, 4'd1, v); chk("R6 count stable over time", v, c);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      rd(1'b0, 4'd1, v);
      chk("R3 nonzero before clear", {31'd0, (v[24:0] != 0)}, 32'h1);
      wr(4'd0, CLR_B);
      idle(200);
      rd(1'b0, 4'd1, v); chk("R3 count zero after clear", v, 32'h0);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_term0();
      logic [31:0] v;
      start_window(20'd0);
      wait_done(2000);
      rd(1'b0, 4'd1, v); chk("R9 zero ticks: done, count 0", v, 32'h0200_0000);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_stopped();
      logic [31:0] v, c;
      measure(20'd100, v);
      c = {7'd0, v[24:0]};
      chk_rate("R7 reference run", c, 100, 0.4);
      wr(4'd0, 32'h0);
      idle(50);
      m0_run = 1'b0;
      idle(100);
      measure(20'd16, v);
      chk("R7 short window stopped clock", v, 32'h0200_0000 | c);
      wr(4'd0, 32'h0);
      measure(20'd256, v);
      chk("R7 long window stopped clock", v, 32'h0200_0000 | c);
      wr(4'd0, 32'h0);
      m0_run = 1'b1;
      idle(100);
   endtask

   task automatic t_saturate();
      logic [31:0] v;
      measure(20'd20, v);
      idle(100);
      rd(1'b1, 4'd1, v); chk("R8 saturated count with done", v, 32'h0200_00FF);
      wr(4'd0, 32'h0);
      idle(200);
      rd(1'b1, 4'd1, v); chk("R8 saturated count held", v, 32'h0000_00FF);
   endtask

   initial begin
      idle(10);
      rst_n = 1'b1;
      idle(10);
      t_reset();
      t_regmap();
      t_branch();
      t_rate();
      t_hold();
      t_clear();
      t_term0();
      t_stopped();
      t_saturate();
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule